// File: doc/BRIEF.md
# BCD Calendar Counter with Staged Update

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (always 24-hour), a weekday index, day of month, month and a two-digit year that counts from a configurable base year (1970 by default, so 00..99 spans 1970..2069). It advances by one second on every cycle in which the one-second tick enable is high. Month lengths follow the calendar. February's length comes from a leap flag that is stored with the year, not from decoding the year.

Software sets the time through a word-wide register port. Writes to the field addresses land in a set of shadow registers and leave the running time alone. A write to the commit address with bit 15 set copies every shadow field, leap flag included, into the live counter on the same clock edge. A set time therefore never shows a mix of old and new fields. Reads always return the live counter, through a combinational read path.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the live time reads second 00, minute 00, hour 00, weekday 0, day 01, month 01, year 00, with the leap flag clear.
- R2: Read addresses: 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year. Each returns the live field in the low bits with zeros above. Bit 15 of address 6 is the leap flag. Address 7 (commit) reads 0 and address 8 (control) reads 16'h0001.
- R3: Writes to addresses 0..6 update only the shadow copy. The live value read back does not change until a commit. Each field keeps only its low bits: second 7, minute 7, hour 6, weekday 3, day 6, month 5, year 8. A write to address 6 also stores bit 15 as the shadow leap flag.
- R4: A write to address 7 with bit 15 = 1 loads all shadow fields into the live counter on that clock edge. A write to address 7 with bit 15 = 0 changes nothing.
- R5: When a commit and a tick occur in the same cycle, the live time equals the shadow values afterwards and that tick is dropped.
- R6: Each cycle with tick high advances the second. Seconds and minutes wrap 59 to 00 and carry. Hours wrap 23 to 00 and carry into the day.
- R7: The weekday counts 0..6, wraps 6 to 0, and advances whenever the day of month advances.
- R8: The last day of a month is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on day 28, or on day 29 when the leap flag is set. After the last day the day returns to 01 and the month advances. Month 12 wraps to 01 and carries into the year.
- R9: The year advances 00..99 and wraps to 00. On each year advance the leap flag becomes set exactly when (base year + new year value) is divisible by 4.
- R10: In a cycle with neither tick nor commit, the live time and leap flag hold.
- R11: The control register always reads bit 0 = 1 (24-hour mode), and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | One-second advance enable, high for one cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The assertions check four things on every cycle: that the live counter holds when idle, that a commit loads the exact shadow image and beats a simultaneous tick, that shadow registers move only on writes, and the local roll-overs (second 59, weekday 6, year 99). The bench's sweeps are the only place where the full carry chain is compared against an arithmetic model. Those sweeps cover every month end for both leap-flag values, every one of the hundred year roll-overs with the recomputed leap flag, and a long run of consecutive ticks across an hour and a midnight. Field masking, ignored commit writes and the fixed control register show only at the read port under directed writes.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int CAL_DW   = 16;
  localparam int CAL_AW   = 4;
  localparam int SEC_W    = 7;
  localparam int MIN_W    = 7;
  localparam int HOUR_W   = 6;
  localparam int WDAY_W   = 3;
  localparam int DAY_W    = 6;
  localparam int MON_W    = 5;
  localparam int YEAR_W   = 8;
  localparam int FLAG_BIT = 15;

  typedef struct packed {
    logic              leap;
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [DAY_W-1:0]  day;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  typedef enum logic [CAL_AW-1:0] {
    A_SEC    = 4'd0,
    A_MIN    = 4'd1,
    A_HOUR   = 4'd2,
    A_WDAY   = 4'd3,
    A_DAY    = 4'd4,
    A_MON    = 4'd5,
    A_YEAR   = 4'd6,
    A_COMMIT = 4'd7,
    A_CTRL   = 4'd8
  } cal_addr_e;

  localparam cal_time_t CAL_RESET = '{
    leap: 1'b0, year: 8'h00, mon: 5'h01, day: 6'h01,
    wday: 3'd0, hour: 6'h00, min: 7'h00, sec: 7'h00
  };

  // Last day of a month (BCD), given BCD month and the stored leap flag.
  function automatic logic [DAY_W-1:0] last_day(input logic [MON_W-1:0] m,
                                                 input logic lp);
    logic [DAY_W-1:0] r;
    case (m)
      5'h02:                      r = lp ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cal_bcd_field.sv
// One BCD field with a wrap value: increments when inc is high,
// returns to LOW after reaching limit and raises wrap.
module cal_bcd_field #(
  parameter int W   = 7,
  parameter int LOW = 0
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] limit,
  input  logic         inc,
  output logic [W-1:0] nxt,
  output logic         wrap
);

  localparam int HI_W = W - 4;

  logic [HI_W-1:0] hi_inc;

  assign hi_inc = val[W-1:4] + 1'b1;

  always_comb begin
    nxt  = val;
    wrap = 1'b0;
    if (inc) begin
      if (val == limit) begin
        nxt  = W'(LOW);
        wrap = 1'b1;
      end else if (val[3:0] == 4'h9) begin
        nxt = {hi_inc, 4'h0};
      end else begin
        nxt = {val[W-1:4], val[3:0] + 4'h1};
      end
    end
  end

endmodule

// File: rtl/cal_shadow.sv
// Shadow field registers written from the register port, plus commit decode.
module cal_shadow
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CAL_AW-1:0] addr,
  input  logic [CAL_DW-1:0] wdata,
  output cal_time_t         shadow,
  output logic              commit
);

  cal_time_t sh_q, sh_d;
  logic      wr_en;

  assign wr_en  = we && (addr <= A_YEAR);
  assign commit = we && (addr == A_COMMIT) && wdata[FLAG_BIT];
  assign shadow = sh_q;

  always_comb begin
    sh_d = sh_q;
    case (addr)
      A_SEC:  sh_d.sec  = wdata[SEC_W-1:0];
      A_MIN:  sh_d.min  = wdata[MIN_W-1:0];
      A_HOUR: sh_d.hour = wdata[HOUR_W-1:0];
      A_WDAY: sh_d.wday = wdata[WDAY_W-1:0];
      A_DAY:  sh_d.day  = wdata[DAY_W-1:0];
      A_MON:  sh_d.mon  = wdata[MON_W-1:0];
      A_YEAR: begin
        sh_d.year = wdata[YEAR_W-1:0];
        sh_d.leap = wdata[FLAG_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= CAL_RESET;
    end else if (wr_en) begin
      sh_q <= sh_d;
    end
  end

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(sh_q)); // R3

endmodule

// File: rtl/cal_counter.sv
// Live calendar counter: carry chain from seconds to year, commit load.
module cal_counter
  import cal_pkg::*;
#(
  parameter int YEAR_BASE = 1970
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      commit,
  input  cal_time_t shadow,
  output cal_time_t live
);

  localparam int BASE_MOD = YEAR_BASE % 4;

  cal_time_t live_q, live_d, adv;
  logic      load_en;

  logic [SEC_W-1:0]  sec_n;
  logic [MIN_W-1:0]  min_n;
  logic [HOUR_W-1:0] hour_n;
  logic [DAY_W-1:0]  day_n;
  logic [MON_W-1:0]  mon_n;
  logic [YEAR_W-1:0] year_n;
  logic [DAY_W-1:0]  day_lim;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap, year_wrap;

  // Leap test on a BCD year: (10*t + o) mod 4 == (2*t + o) mod 4.
  function automatic logic leap_of(input logic [YEAR_W-1:0] y);
    logic [5:0] s;
    s = {1'b0, y[7:4], 1'b0} + {2'b00, y[3:0]} + 6'(BASE_MOD);
    return (s[1:0] == 2'b00);
  endfunction

  assign day_lim = last_day(live_q.mon, live_q.leap);

  cal_bcd_field #(.W(SEC_W), .LOW(0)) u_sec (
    .val(live_q.sec), .limit(7'h59), .inc(tick),
    .nxt(sec_n), .wrap(sec_wrap));

  cal_bcd_field #(.W(MIN_W), .LOW(0)) u_min (
    .val(live_q.min), .limit(7'h59), .inc(sec_wrap),
    .nxt(min_n), .wrap(min_wrap));

  cal_bcd_field #(.W(HOUR_W), .LOW(0)) u_hour (
    .val(live_q.hour), .limit(6'h23), .inc(min_wrap),
    .nxt(hour_n), .wrap(hour_wrap));

  cal_bcd_field #(.W(DAY_W), .LOW(1)) u_day (
    .val(live_q.day), .limit(day_lim), .inc(hour_wrap),
    .nxt(day_n), .wrap(day_wrap));

  cal_bcd_field #(.W(MON_W), .LOW(1)) u_mon (
    .val(live_q.mon), .limit(5'h12), .inc(day_wrap),
    .nxt(mon_n), .wrap(mon_wrap));

  cal_bcd_field #(.W(YEAR_W), .LOW(0)) u_year (
    .val(live_q.year), .limit(8'h99), .inc(mon_wrap),
    .nxt(year_n), .wrap(year_wrap));

  always_comb begin
    adv      = live_q;
    adv.sec  = sec_n;
    adv.min  = min_n;
    adv.hour = hour_n;
    adv.day  = day_n;
    adv.mon  = mon_n;
    adv.year = year_n;
    if (hour_wrap) begin
      adv.wday = (live_q.wday >= 3'd6) ? 3'd0 : live_q.wday + 3'd1;
    end
    if (mon_wrap) begin
      adv.leap = leap_of(year_n);
    end
  end

  // Commit has priority; a tick in the same cycle is dropped.
  assign load_en = commit || tick;

  always_comb begin
    live_d = adv;
    if (commit) begin
      live_d = shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= CAL_RESET;
    end else if (load_en) begin
      live_q <= live_d;
    end
  end

  assign live = live_q;

  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live_q == $past(shadow)); // R4

  AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && tick) |=> live_q.sec == $past(shadow.sec)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !tick) |=> $stable(live_q)); // R10

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && tick && live_q.sec == 7'h59) |=> live_q.sec == 7'h00); // R6

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && hour_wrap && live_q.wday == 3'd6) |=> live_q.wday == 3'd0); // R7

  AST_YEAR_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && mon_wrap && live_q.year == 8'h99)
      |=> (live_q.year == 8'h00) && (live_q.leap == (BASE_MOD == 0))); // R9

endmodule

// File: rtl/cal_readmux.sv
// Combinational read path: live fields, commit (reads 0), control.
module cal_readmux
  import cal_pkg::*;
(
  input  logic [CAL_AW-1:0] addr,
  input  cal_time_t         live,
  output logic [CAL_DW-1:0] rdata
);

  always_comb begin
    rdata = '0;
    case (addr)
      A_SEC:  rdata[SEC_W-1:0]  = live.sec;
      A_MIN:  rdata[MIN_W-1:0]  = live.min;
      A_HOUR: rdata[HOUR_W-1:0] = live.hour;
      A_WDAY: rdata[WDAY_W-1:0] = live.wday;
      A_DAY:  rdata[DAY_W-1:0]  = live.day;
      A_MON:  rdata[MON_W-1:0]  = live.mon;
      A_YEAR: begin
        rdata[YEAR_W-1:0] = live.year;
        rdata[FLAG_BIT]   = live.leap;
      end
      A_CTRL: rdata[0] = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int YEAR_BASE = 1970
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_we,
  input  logic [CAL_AW-1:0] reg_addr,
  input  logic [CAL_DW-1:0] reg_wdata,
  output logic [CAL_DW-1:0] reg_rdata
);

  cal_time_t shadow;
  cal_time_t live;
  logic      commit;

  cal_shadow u_shadow (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .shadow (shadow),
    .commit (commit)
  );

  cal_counter #(.YEAR_BASE(YEAR_BASE)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .commit (commit),
    .shadow (shadow),
    .live   (live)
  );

  cal_readmux u_rd (
    .addr  (reg_addr),
    .live  (live),
    .rdata (reg_rdata)
  );

endmodule

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model in plain binary.
  int m_sec, m_min, m_hour, m_wday, m_day, m_mon, m_year, m_leap;

  always #5 clk = ~clk;

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int lp);
    if (mo == 2) return lp ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0; m_wday = (m_wday + 1) % 7; m_day++;
          if (m_day > mdays(m_mon, m_leap)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon  = 1;
              m_year = (m_year + 1) % 100;
              m_leap = ((1970 + m_year) % 4 == 0) ? 1 : 0;
            end
          end
        end
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check_val(input string tag, input logic [15:0] act,
                           input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [111:0] act, exp;
    logic [15:0]  d;
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), d);
      act[i*16 +: 16] = d;
    end
    exp = '0;
    exp[0*16 +: 16]  = {8'h00, bcd(m_sec)};
    exp[1*16 +: 16]  = {8'h00, bcd(m_min)};
    exp[2*16 +: 16]  = {8'h00, bcd(m_hour)};
    exp[3*16 +: 16]  = 16'(m_wday);
    exp[4*16 +: 16]  = {8'h00, bcd(m_day)};
    exp[5*16 +: 16]  = {8'h00, bcd(m_mon)};
    exp[6*16 +: 16]  = {m_leap[0], 7'h00, bcd(m_year)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_shadow(input int s, input int mi, input int h,
                             input int wd, input int d, input int mo,
                             input int y, input int lp);
    wr(4'd0, {8'h00, bcd(s)});
    wr(4'd1, {8'h00, bcd(mi)});
    wr(4'd2, {8'h00, bcd(h)});
    wr(4'd3, 16'(wd));
    wr(4'd4, {8'h00, bcd(d)});
    wr(4'd5, {8'h00, bcd(mo)});
    wr(4'd6, {lp[0], 7'h00, bcd(y)});
  endtask

  task automatic set_time(input int s, input int mi, input int h,
                          input int wd, input int d, input int mo,
                          input int y, input int lp);
    load_shadow(s, mi, h, wd, d, mo, y, lp);
    wr(4'd7, 16'h8000);
    m_sec = s; m_min = mi; m_hour = h; m_wday = wd;
    m_day = d; m_mon = mo; m_year = y; m_leap = lp;
  endtask

  task automatic print_summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      print_summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; tick = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents
    m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0;
    m_day = 1; m_mon = 1; m_year = 0; m_leap = 0;
    check_all("R1 reset");

    // R2: commit and control addresses
    rd(4'd7, d); check_val("R2 commit reads zero", d, 16'h0000);
    rd(4'd8, d); check_val("R2 control read", d, 16'h0001);

    // R11: control write ignored
    wr(4'd8, 16'h0000);
    rd(4'd8, d); check_val("R11 control after write", d, 16'h0001);

    // R10: hold without tick
    set_time(12, 34, 5, 2, 15, 7, 33, 0);
    repeat (20) @(negedge clk);
    check_all("R10 hold");

    // R3: shadow write invisible until commit
    load_shadow(1, 2, 3, 4, 5, 6, 7, 0);
    check_all("R3 shadow not live");
    wr(4'd7, 16'h8000);
    m_sec = 1; m_min = 2; m_hour = 3; m_wday = 4;
    m_day = 5; m_mon = 6; m_year = 7; m_leap = 0;
    check_all("R4 commit loads");

    // R3: field masking
    wr(4'd0, 16'hFF25); wr(4'd1, 16'hFF47); wr(4'd2, 16'hFFD7);
    wr(4'd3, 16'hFFFD); wr(4'd4, 16'hFFD9); wr(4'd5, 16'hFFE9);
    wr(4'd6, 16'hFF42); wr(4'd7, 16'h8000);
    m_sec = 25; m_min = 47; m_hour = 17; m_wday = 5;
    m_day = 19; m_mon = 9; m_year = 42; m_leap = 1;
    check_all("R3 masking");

    // R4: commit without bit 15 is ignored
    load_shadow(11, 11, 11, 1, 11, 11, 11, 0);
    wr(4'd7, 16'h7FFF);
    check_all("R4 no commit bit");

    // R5: commit with simultaneous tick
    load_shadow(30, 20, 10, 3, 4, 5, 6, 0);
    @(negedge clk);
    tick = 1'b1; reg_we = 1'b1; reg_addr = 4'd7; reg_wdata = 16'h8000;
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0;
    m_sec = 30; m_min = 20; m_hour = 10; m_wday = 3;
    m_day = 4; m_mon = 5; m_year = 6; m_leap = 0;
    check_all("R5 commit beats tick");

    // R8 / R7: every month end with both leap flag values
    for (int lp = 0; lp < 2; lp++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_time(59, 59, 23, 6, mdays(mo, lp), mo, 57, lp);
        do_tick();
        model_adv();
        check_all("R8 month end R7 wday");
      end
    end

    // R8: Feb 28 with leap flag goes to Feb 29
    set_time(59, 59, 23, 1, 28, 2, 2, 1);
    do_tick(); model_adv();
    check_all("R8 feb 29");

    // R9: every year roll with leap recomputation
    for (int y = 0; y < 100; y++) begin
      set_time(59, 59, 23, y % 7, 31, 12, y, 0);
      do_tick(); model_adv();
      check_all("R9 year roll");
    end

    // R6: long run of consecutive ticks across an hour and midnight
    set_time(0, 58, 22, 3, 28, 2, 2, 1);
    for (int i = 0; i < 4000; i++) begin
      do_tick(); model_adv();
      check_all("R6 tick run");
    end

    done = 1'b1;
    print_summary();
    $finish;
  end

endmodule